// File: doc/BRIEF.md
# Clear-on-Read Conversion Result Bank

This block is a small bank of 16-bit conversion-result registers that sits between an analog-to-digital conversion sequencer and a register bus. When the sequencer finishes a conversion it writes the result to the register for that channel. Two bus masters can read the bank: a CPU port and a DMA transfer port. Each master presents a read strobe and an index. Each port returns its data one cycle later, together with a valid pulse.

A run-time enable selects how reads behave. When the enable is set, a read returns the stored value and the register is then zeroed. Software can therefore spot a conversion that never arrived, because its readback is zero. When the enable is clear, reads leave the bank untouched. Each register also has a sticky "fresh" flag. The flag is set by a write and cleared by a granted read. Only one read is served per cycle, and the CPU has fixed priority over the DMA port.

Top module: `adc_result_bank`

## Requirements
- R1: After synchronous reset every register reads 0x0000, every fresh flag is 0 and both read-valid outputs are 0.
- R2: A converter write (`wr_en`) loads `wr_data` into register `wr_idx` at the next clock edge and sets fresh flag bit `wr_idx`.
- R3: A granted read returns the register's value from before the strobe edge. The value appears on the port's data output with its valid high exactly one cycle after the strobe.
- R4: With `auto_clr_en` = 1, a granted read sets the addressed register to 0x0000 at the same edge that captures the read data.
- R5: With `auto_clr_en` = 0, reads never change a register, so repeated reads return the same value.
- R6: With `auto_clr_en` = 1, a second read of a register that has not been written since the first read returns 0x0000.
- R7: When both masters strobe in the same cycle, only the CPU read is granted. The DMA valid stays low for that request, and the DMA request neither clears the register nor clears its fresh flag.
- R8: If a converter write and a granted read address the same register in one cycle, the read returns the old value. The register then holds the new data and its fresh flag stays set.
- R9: A granted read clears the addressed fresh flag whatever the value of `auto_clr_en`.
- R10: A granted DMA read returns data and clears the register under the same rules as a CPU read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_clr_en | input | 1 | 1: a granted read zeroes the register |
| wr_en | input | 1 | Converter result strobe |
| wr_idx | input | IDXW | Register written by the converter |
| wr_data | input | DW | Conversion result or accumulated sum |
| cpu_rd_en | input | 1 | CPU read strobe |
| cpu_rd_idx | input | IDXW | CPU read index |
| dma_rd_en | input | 1 | DMA read strobe |
| dma_rd_idx | input | IDXW | DMA read index |
| cpu_rd_data | output | DW | CPU read data, registered |
| cpu_rd_valid | output | 1 | CPU read data valid |
| dma_rd_data | output | DW | DMA read data, registered |
| dma_rd_valid | output | 1 | DMA read data valid |
| fresh_flags | output | NREG | Per-register written-since-last-read flags |

## Verification
The bench first runs the bank with clearing disabled, where repeated reads of a written register must return the same value. This separates a hold from a clear. With clearing enabled, it reads twice without writing in between, which tells a zero readback caused by a missed update apart from stale data. It then issues simultaneous CPU and DMA strobes, once to the same register and once to different registers, to show that only the CPU is served and that the losing request leaves no trace. A write to the register being read in that same cycle shows that the converter result survives the clear while the read returns the old value.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;

  typedef enum logic [1:0] {
    GRANT_NONE = 2'd0,
    GRANT_CPU  = 2'd1,
    GRANT_DMA  = 2'd2
  } grant_e;

endpackage

// File: rtl/rr_read_arbiter.sv
module rr_read_arbiter
  import adc_rr_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic            cpu_en,
  input  logic [IDXW-1:0] cpu_idx,
  input  logic            dma_en,
  input  logic [IDXW-1:0] dma_idx,
  output grant_e          grant,
  output logic [IDXW-1:0] gnt_idx,
  output logic            gnt_any
);

  // Fixed priority: the CPU wins every conflict.
  always_comb begin
    grant   = GRANT_NONE;
    gnt_idx = '0;
    if (cpu_en) begin
      grant   = GRANT_CPU;
      gnt_idx = cpu_idx;
    end else if (dma_en) begin
      grant   = GRANT_DMA;
      gnt_idx = dma_idx;
    end
  end

  assign gnt_any = cpu_en | dma_en;

endmodule

// File: rtl/rr_result_store.sv
module rr_result_store #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int IDXW = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDXW-1:0]          wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic                     clr_en,
  input  logic [IDXW-1:0]          clr_idx,
  input  logic [IDXW-1:0]          rd_idx,
  output logic [DW-1:0]            rd_data,
  output logic [NREG-1:0][DW-1:0]  bank
);

  // One flop word per register: a write and a clear to different
  // registers must both land in the same cycle.
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit_wr;
    logic hit_clr;
    assign hit_wr  = wr_en  && (wr_idx  == IDXW'(g));
    assign hit_clr = clr_en && (clr_idx == IDXW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        bank[g] <= '0;
      end else if (hit_wr) begin
        bank[g] <= wr_data;      // converter result beats the clear
      end else if (hit_clr) begin
        bank[g] <= '0;
      end
    end
  end

  // Read of the value before the edge (read-before-write).
  assign rd_data = bank[rd_idx];

endmodule

// File: rtl/rr_fresh_flags.sv
module rr_fresh_flags #(
  parameter int NREG = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [IDXW-1:0] set_idx,
  input  logic            clr_en,
  input  logic [IDXW-1:0] clr_idx,
  output logic [NREG-1:0] flags
);

  for (genvar g = 0; g < NREG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[g] <= 1'b0;
      end else if (set_en && (set_idx == IDXW'(g))) begin
        flags[g] <= 1'b1;
      end else if (clr_en && (clr_idx == IDXW'(g))) begin
        flags[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rr_read_port.sv
module rr_read_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_q,
  output logic          valid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) begin
        data_q <= data_in;
      end
    end
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_rr_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            auto_clr_en,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            cpu_rd_en,
  input  logic [IDXW-1:0] cpu_rd_idx,
  input  logic            dma_rd_en,
  input  logic [IDXW-1:0] dma_rd_idx,
  output logic [DW-1:0]   cpu_rd_data,
  output logic            cpu_rd_valid,
  output logic [DW-1:0]   dma_rd_data,
  output logic            dma_rd_valid,
  output logic [NREG-1:0] fresh_flags
);

  grant_e                    grant;
  logic [IDXW-1:0]           gnt_idx;
  logic                      gnt_any;
  logic [DW-1:0]             sel_data;
  logic [NREG-1:0][DW-1:0]   bank_q;
  logic                      clr_en;

  rr_read_arbiter #(.IDXW(IDXW)) u_arb (
    .cpu_en  (cpu_rd_en),
    .cpu_idx (cpu_rd_idx),
    .dma_en  (dma_rd_en),
    .dma_idx (dma_rd_idx),
    .grant   (grant),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  assign clr_en = gnt_any & auto_clr_en;

  rr_result_store #(.NREG(NREG), .DW(DW), .IDXW(IDXW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .clr_en  (clr_en),
    .clr_idx (gnt_idx),
    .rd_idx  (gnt_idx),
    .rd_data (sel_data),
    .bank    (bank_q)
  );

  rr_fresh_flags #(.NREG(NREG), .IDXW(IDXW)) u_fresh (
    .clk     (clk),
    .rst     (rst),
    .set_en  (wr_en),
    .set_idx (wr_idx),
    .clr_en  (gnt_any),
    .clr_idx (gnt_idx),
    .flags   (fresh_flags)
  );

  rr_read_port #(.DW(DW)) u_cpu_port (
    .clk     (clk),
    .rst     (rst),
    .take    (grant == GRANT_CPU),
    .data_in (sel_data),
    .data_q  (cpu_rd_data),
    .valid_q (cpu_rd_valid)
  );

  rr_read_port #(.DW(DW)) u_dma_port (
    .clk     (clk),
    .rst     (rst),
    .take    (grant == GRANT_DMA),
    .data_in (sel_data),
    .data_q  (dma_rd_data),
    .valid_q (dma_rd_valid)
  );

endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int IDXW = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    auto_clr_en,
  input logic                    wr_en,
  input logic [IDXW-1:0]         wr_idx,
  input logic [DW-1:0]           wr_data,
  input logic                    cpu_rd_en,
  input logic [IDXW-1:0]         cpu_rd_idx,
  input logic                    dma_rd_en,
  input logic [DW-1:0]           cpu_rd_data,
  input logic                    cpu_rd_valid,
  input logic                    dma_rd_valid,
  input logic [NREG-1:0]         fresh_flags,
  input logic [NREG-1:0][DW-1:0] bank_q
);

  logic cpu_hit_wr;
  assign cpu_hit_wr = wr_en && (wr_idx == cpu_rd_idx);

  a_r7_cpu_first: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_en && dma_rd_en) |=> (cpu_rd_valid && !dma_rd_valid));

  a_r3_cpu_valid: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_en |=> cpu_rd_valid);

  a_r3_pre_clear_data: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_en |=> (cpu_rd_data == $past(bank_q[cpu_rd_idx])));

  a_r10_dma_served: assert property (@(posedge clk) disable iff (rst)
    (dma_rd_en && !cpu_rd_en) |=> dma_rd_valid);

  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_en && auto_clr_en && !cpu_hit_wr) |=> (bank_q[$past(cpu_rd_idx)] == '0));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_en && !auto_clr_en && !cpu_hit_wr)
      |=> (bank_q[$past(cpu_rd_idx)] == $past(bank_q[cpu_rd_idx])));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (bank_q[$past(wr_idx)] == $past(wr_data)));

  a_r2_fresh_set: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> fresh_flags[$past(wr_idx)]);

  a_r9_fresh_clear: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_en && !cpu_hit_wr) |=> !fresh_flags[$past(cpu_rd_idx)]);

endmodule

bind adc_result_bank adc_result_bank_chk #(.NREG(NREG), .DW(DW), .IDXW(IDXW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .auto_clr_en  (auto_clr_en),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .wr_data      (wr_data),
  .cpu_rd_en    (cpu_rd_en),
  .cpu_rd_idx   (cpu_rd_idx),
  .dma_rd_en    (dma_rd_en),
  .cpu_rd_data  (cpu_rd_data),
  .cpu_rd_valid (cpu_rd_valid),
  .dma_rd_valid (dma_rd_valid),
  .fresh_flags  (fresh_flags),
  .bank_q       (bank_q)
);

// File: tb/adc_result_bank_tb.sv
module adc_result_bank_tb;

  localparam int NREG   = 8;
  localparam int DW     = 16;
  localparam int IDXW   = 3;
  localparam int CLK_NS = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            auto_clr_en = 1'b0;
  logic            wr_en = 1'b0;
  logic [IDXW-1:0] wr_idx = '0;
  logic [DW-1:0]   wr_data = '0;
  logic            cpu_rd_en = 1'b0;
  logic [IDXW-1:0] cpu_rd_idx = '0;
  logic            dma_rd_en = 1'b0;
  logic [IDXW-1:0] dma_rd_idx = '0;
  logic [DW-1:0]   cpu_rd_data;
  logic            cpu_rd_valid;
  logic [DW-1:0]   dma_rd_data;
  logic            dma_rd_valid;
  logic [NREG-1:0] fresh_flags;

  int checks = 0;
  int failures = 0;

  // Requirement model
  logic [DW-1:0]   m_bank [NREG];
  logic [NREG-1:0] m_fresh;

  logic [DW-1:0] cpu_q[$];
  string         cpu_tag_q[$];
  logic [DW-1:0] dma_q[$];
  string         dma_tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  adc_result_bank #(.NREG(NREG), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .auto_clr_en(auto_clr_en),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_idx(cpu_rd_idx),
    .dma_rd_en(dma_rd_en), .dma_rd_idx(dma_rd_idx),
    .cpu_rd_data(cpu_rd_data), .cpu_rd_valid(cpu_rd_valid),
    .dma_rd_data(dma_rd_data), .dma_rd_valid(dma_rd_valid),
    .fresh_flags(fresh_flags)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one bus cycle, expected reads pushed to the scoreboard.
  task automatic cycle(input bit w, input int wi, input logic [DW-1:0] wd,
                       input bit c, input int ci, input bit d, input int di,
                       input string tag);
    int gi;
    @(negedge clk);
    wr_en = w; wr_idx = IDXW'(wi); wr_data = wd;
    cpu_rd_en = c; cpu_rd_idx = IDXW'(ci);
    dma_rd_en = d; dma_rd_idx = IDXW'(di);
    gi = c ? ci : di;
    if (c) begin
      cpu_q.push_back(m_bank[ci]); cpu_tag_q.push_back(tag);
    end else if (d) begin
      dma_q.push_back(m_bank[di]); dma_tag_q.push_back(tag);
    end
    if (c || d) begin
      if (auto_clr_en) m_bank[gi] = '0;
      m_fresh[gi] = 1'b0;
    end
    if (w) begin
      m_bank[wi] = wd;
      m_fresh[wi] = 1'b1;
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0; cpu_rd_en = 1'b0; dma_rd_en = 1'b0;
  endtask

  task automatic check_fresh(input string req);
    @(negedge clk);
    check(fresh_flags == m_fresh, req, 32'(fresh_flags), 32'(m_fresh));
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (cpu_rd_valid) begin
        if (cpu_q.size() == 0) begin
          check(1'b0, "R3 unexpected cpu valid", 32'(cpu_rd_data), 32'h0);
        end else begin
          automatic logic [DW-1:0] e = cpu_q.pop_front();
          automatic string t = cpu_tag_q.pop_front();
          check(cpu_rd_data == e, t, 32'(cpu_rd_data), 32'(e));
        end
      end
      if (dma_rd_valid) begin
        if (dma_q.size() == 0) begin
          check(1'b0, "R7 unexpected dma valid", 32'(dma_rd_data), 32'h0);
        end else begin
          automatic logic [DW-1:0] e = dma_q.pop_front();
          automatic string t = dma_tag_q.pop_front();
          check(dma_rd_data == e, t, 32'(dma_rd_data), 32'(e));
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_NS * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) m_bank[i] = '0;
    m_fresh = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check(!cpu_rd_valid && !dma_rd_valid, "R1 valids after reset",
          32'({cpu_rd_valid, dma_rd_valid}), 32'h0);
    check(fresh_flags == '0, "R1 fresh after reset", 32'(fresh_flags), 32'h0);
    for (int i = 0; i < NREG; i++) cycle(0, 0, '0, 1, i, 0, 0, "R1 reset value");

    // R2 write then R5 repeated reads with clearing off
    cycle(1, 2, 16'h0111, 0, 0, 0, 0, "R2");
    cycle(1, 5, 16'hFFF0, 0, 0, 0, 0, "R2");
    check_fresh("R2 fresh set on write");
    cycle(0, 0, '0, 1, 2, 0, 0, "R5 first read no clear");
    cycle(0, 0, '0, 1, 2, 0, 0, "R5 second read same value");
    cycle(0, 0, '0, 0, 0, 1, 5, "R5 dma read no clear");
    cycle(0, 0, '0, 0, 0, 1, 5, "R5 dma repeat read");
    check_fresh("R9 fresh cleared with clearing off");

    // R4 / R6 clear on read
    auto_clr_en = 1'b1;
    cycle(0, 0, '0, 1, 2, 0, 0, "R4 read returns pre-clear value");
    cycle(0, 0, '0, 1, 2, 0, 0, "R6 missed update reads zero");
    cycle(1, 3, 16'h0222, 0, 0, 0, 0, "R2");
    cycle(0, 0, '0, 1, 3, 0, 0, "R3 new result after clear");
    cycle(0, 0, '0, 1, 3, 0, 0, "R6 zero after second read");

    // R10 DMA clears
    cycle(0, 0, '0, 0, 0, 1, 5, "R10 dma read pre-clear value");
    cycle(0, 0, '0, 0, 0, 1, 5, "R10 dma read after clear is zero");

    // R7 priority: different registers, then same register
    cycle(1, 1, 16'h0AB1, 0, 0, 0, 0, "R2");
    cycle(1, 4, 16'h0C04, 0, 0, 0, 0, "R2");
    cycle(0, 0, '0, 1, 1, 1, 4, "R7 cpu granted over dma");
    check_fresh("R7 losing dma leaves fresh flag");
    cycle(0, 0, '0, 0, 0, 1, 4, "R7 losing dma left register intact");
    cycle(1, 6, 16'h0666, 0, 0, 0, 0, "R2");
    cycle(0, 0, '0, 1, 6, 1, 6, "R7 same register cpu wins");
    cycle(0, 0, '0, 0, 0, 1, 6, "R7 register cleared once by cpu");

    // R8 collision
    cycle(1, 7, 16'h0100, 0, 0, 0, 0, "R2");
    cycle(1, 7, 16'h0200, 1, 7, 0, 0, "R8 collision returns old value");
    check_fresh("R8 fresh kept on collision");
    cycle(0, 0, '0, 1, 7, 0, 0, "R8 new data survived clear");
    cycle(1, 0, 16'h0300, 0, 0, 1, 0, "R8 dma collision old value");
    cycle(0, 0, '0, 0, 0, 1, 0, "R8 dma new data survived");
    check_fresh("R9 fresh after reads");

    repeat (3) @(negedge clk);
    check(cpu_q.size() == 0 && dma_q.size() == 0, "R3 all reads answered",
          32'(cpu_q.size() + dma_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule